// File: doc/BRIEF.md
# Attribute-Driven Scanline Pixel Renderer

This block draws one video scanline. It takes in the bytes of the line one at a time and sends out six 3-bit RGB pixels for each byte, one pixel per clock. A byte whose bits 6 and 5 are both clear is not picture data. It is an in-band control code that changes the renderer's drawing state at once: foreground colour, background colour, character style (alternate glyph set, double height, blinking), or display mode (bitmap or character, plus a refresh-rate flag). Such a byte still takes up six pixels on screen. Those pixels are drawn in the background colour.

In bitmap mode the six low bits of a data byte are the pixels. In character mode the seven low bits are a character code. The renderer sends that code, with the glyph row it computed, a set-select bit and a request strobe, to an outside character generator. The generator returns the six-pixel glyph slice on the next cycle, and the renderer holds its pixel output until that slice has arrived. Bit 7 of any byte inverts the colours of that byte's own six pixels. A `line_start` pulse between lines restores the per-line drawing defaults. The display mode carries over from one line to the next.

Top module: `vlr_line_render`

## Requirements
- R1: Each accepted byte yields exactly 6 pixels on consecutive `pix_valid` cycles, leftmost from pattern bit 5 down to bit 0, so 40 bytes give 240 pixels.
- R2: A byte with bits 6:5 = 00 is a control code (low 5 bits). It yields 6 pixels of background colour, and `pix_valid` rises on the cycle after it is accepted.
- R3: Control code bits 4:3 select a group: 00 loads foreground from bits 2:0, 10 loads background from bits 2:0. The colour value is {blue,green,red}, with 0 black, 1 red, 2 green, 3 yellow, 4 blue, 5 magenta, 6 cyan, 7 white. A background change already applies to the code's own 6 pixels.
- R4: Group 01 loads the character style: bit 0 alternate set (driven on `glyph_alt` with later requests), bit 1 double height, bit 2 blinking.
- R5: Group 11 loads the mode: bit 2 bitmap mode (`mode_hires`), bit 1 50 Hz flag (`mode_50hz`). Both are 0 after reset, and `line_start` does not change them.
- R6: `line_start` sets foreground white, background black, and clears blinking, double height and alternate set before the next byte is decoded.
- R7: In bitmap mode a data byte's bits 5:0 are its pixels: 1 gives foreground, 0 gives background.
- R8: In character mode a data byte raises `glyph_req` for exactly one cycle, the cycle after it is accepted, with `glyph_code` = bits 6:0. `glyph_data` is sampled on the following cycle, and pixels start on the cycle after that. 1 gives foreground, 0 gives background.
- R9: Bit 7 of a byte inverts all three RGB bits of that byte's 6 pixels only.
- R10: When blinking is set and `blink_phase` is 1 at acceptance, a character byte's pixels are all background colour.
- R11: With double height set, `glyph_row` = {`dbl_lower`, `row[2:1]`}. Otherwise it equals `row`.
- R12: `in_ready` is 1 when idle or on the last pixel of a byte, and 0 at every other time. A byte's pixel burst is never interrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Restore per-line drawing defaults |
| in_valid | input | 1 | Screen byte offered |
| in_data | input | 8 | Screen byte |
| in_ready | output | 1 | Renderer can take a byte this cycle |
| row | input | 3 | Row inside the character cell |
| blink_phase | input | 1 | Blink phase, 1 hides blinking characters |
| dbl_lower | input | 1 | Selects lower half of double-height glyphs |
| glyph_req | output | 1 | Glyph lookup strobe |
| glyph_code | output | 7 | Character code for lookup |
| glyph_row | output | 3 | Glyph row for lookup |
| glyph_alt | output | 1 | Alternate glyph set select |
| glyph_data | input | 6 | Glyph slice, valid the cycle after the strobe |
| pix_valid | output | 1 | Pixel strobe |
| pix_rgb | output | 3 | Pixel colour {blue,green,red} |
| mode_hires | output | 1 | Bitmap mode active |
| mode_50hz | output | 1 | 50 Hz flag |

## Verification
Properties check the sequencing on every cycle. A glyph strobe lasts one cycle and is followed by one silent cycle and then pixels. A control code produces pixels on the next cycle. A burst is never broken while input is stalled. Colour and mode registers load or hold according to the control code and `line_start`. The colours of individual pixels can only be shown by the bench. It compares every pixel against a model that tracks the drawing state, across lines that cycle through all 256 byte values, every row, both blink phases and both half-select values. The bench also checks lookup fields and line-boundary defaults.

// File: rtl/vlr_pkg.sv
package vlr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_GLYPH = 2'd2,
        ST_EMIT  = 2'd3
    } vlr_state_e;

    typedef struct packed {
        logic [2:0] fg;
        logic [2:0] bg;
        logic       alt;
        logic       dbl;
        logic       blink;
        logic       hires;
        logic       hz50;
    } vlr_attr_t;

    localparam logic [2:0] COL_BLACK = 3'd0;
    localparam logic [2:0] COL_WHITE = 3'd7;

    localparam logic [1:0] GRP_FG   = 2'b00;
    localparam logic [1:0] GRP_TEXT = 2'b01;
    localparam logic [1:0] GRP_BG   = 2'b10;
    localparam logic [1:0] GRP_MODE = 2'b11;

    // Per-line defaults; display mode is carried over.
    function automatic vlr_attr_t line_defaults(input vlr_attr_t a);
        vlr_attr_t r;
        r       = a;
        r.fg    = COL_WHITE;
        r.bg    = COL_BLACK;
        r.alt   = 1'b0;
        r.dbl   = 1'b0;
        r.blink = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/vlr_attr_decode.sv
module vlr_attr_decode
    import vlr_pkg::*;
(
    input  logic [7:0] code_i,
    input  vlr_attr_t  cur_i,
    output logic       is_attr_o,
    output vlr_attr_t  nxt_o
);
    always_comb begin
        is_attr_o = (code_i[6:5] == 2'b00);
        nxt_o     = cur_i;
        if (is_attr_o) begin
            unique case (code_i[4:3])
                GRP_FG:   nxt_o.fg = code_i[2:0];
                GRP_TEXT: begin
                    nxt_o.alt   = code_i[0];
                    nxt_o.dbl   = code_i[1];
                    nxt_o.blink = code_i[2];
                end
                GRP_BG:   nxt_o.bg = code_i[2:0];
                GRP_MODE: begin
                    nxt_o.hz50  = code_i[1];
                    nxt_o.hires = code_i[2];
                end
                default:  nxt_o = cur_i;
            endcase
        end
    end
endmodule

// File: rtl/vlr_glyph_row.sv
module vlr_glyph_row #(
    parameter int ROW_W = 3
) (
    input  logic [ROW_W-1:0] row_i,
    input  logic             dbl_i,
    input  logic             lower_i,
    output logic [ROW_W-1:0] row_o
);
    // Double height stretches one half of the glyph over all rows.
    always_comb begin
        if (dbl_i) row_o = {lower_i, row_i[ROW_W-1:1]};
        else       row_o = row_i;
    end
endmodule

// File: rtl/vlr_pixel_mux.sv
module vlr_pixel_mux #(
    parameter int PIX   = 6,
    parameter int CNT_W = 3
) (
    input  logic [PIX-1:0]   pat_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [2:0]       fg_i,
    input  logic [2:0]       bg_i,
    input  logic             inv_i,
    output logic [2:0]       rgb_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PIX - 1);

    logic [CNT_W-1:0] idx;
    logic             sel;

    always_comb begin
        idx   = LAST - cnt_i;
        sel   = pat_i[idx];
        rgb_o = (sel ? fg_i : bg_i) ^ {3{inv_i}};
    end
endmodule

// File: rtl/vlr_line_render.sv
module vlr_line_render
    import vlr_pkg::*;
#(
    parameter int PIX_PER_BYTE = 6,
    parameter int ROW_W        = 3,
    parameter int CODE_W       = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    line_start,
    input  logic                    in_valid,
    input  logic [7:0]              in_data,
    output logic                    in_ready,
    input  logic [ROW_W-1:0]        row,
    input  logic                    blink_phase,
    input  logic                    dbl_lower,
    output logic                    glyph_req,
    output logic [CODE_W-1:0]       glyph_code,
    output logic [ROW_W-1:0]        glyph_row,
    output logic                    glyph_alt,
    input  logic [PIX_PER_BYTE-1:0] glyph_data,
    output logic                    pix_valid,
    output logic [2:0]              pix_rgb,
    output logic                    mode_hires,
    output logic                    mode_50hz
);
    localparam int               CNT_W = $clog2(PIX_PER_BYTE);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(PIX_PER_BYTE - 1);

    typedef struct packed {
        vlr_state_e              st;
        vlr_attr_t               at;
        logic [PIX_PER_BYTE-1:0] pat;
        logic                    inv;
        logic                    blank;
        logic [CNT_W-1:0]        cnt;
        logic [CODE_W-1:0]       code;
        logic [ROW_W-1:0]        grow;
        logic                    galt;
    } regs_t;

    localparam vlr_attr_t ATTR_RST = '{fg: COL_WHITE, bg: COL_BLACK,
                                       alt: 1'b0, dbl: 1'b0, blink: 1'b0,
                                       hires: 1'b0, hz50: 1'b0};

    regs_t     r_q, r_d;
    vlr_attr_t at_base;
    vlr_attr_t dec_attr;
    logic      dec_is_attr;
    logic [ROW_W-1:0] map_row;
    logic      accept;

    always_comb at_base = line_start ? line_defaults(r_q.at) : r_q.at;

    vlr_attr_decode u_dec (
        .code_i   (in_data),
        .cur_i    (at_base),
        .is_attr_o(dec_is_attr),
        .nxt_o    (dec_attr)
    );

    vlr_glyph_row #(.ROW_W(ROW_W)) u_row (
        .row_i  (row),
        .dbl_i  (at_base.dbl),
        .lower_i(dbl_lower),
        .row_o  (map_row)
    );

    vlr_pixel_mux #(.PIX(PIX_PER_BYTE), .CNT_W(CNT_W)) u_mux (
        .pat_i(r_q.pat),
        .cnt_i(r_q.cnt),
        .fg_i (r_q.at.fg),
        .bg_i (r_q.at.bg),
        .inv_i(r_q.inv),
        .rgb_o(pix_rgb)
    );

    always_comb begin
        in_ready = (r_q.st == ST_IDLE) || ((r_q.st == ST_EMIT) && (r_q.cnt == LAST));
        accept   = in_valid && in_ready;

        r_d    = r_q;
        r_d.at = at_base;

        unique case (r_q.st)
            ST_IDLE:  r_d.st = ST_IDLE;
            ST_REQ:   r_d.st = ST_GLYPH;
            ST_GLYPH: begin
                r_d.pat = r_q.blank ? '0 : glyph_data;
                r_d.cnt = '0;
                r_d.st  = ST_EMIT;
            end
            ST_EMIT: begin
                if (r_q.cnt == LAST) r_d.st = ST_IDLE;
                else                 r_d.cnt = r_q.cnt + 1'b1;
            end
            default:  r_d.st = ST_IDLE;
        endcase

        if (accept) begin
            r_d.at  = dec_attr;
            r_d.inv = in_data[7];
            r_d.cnt = '0;
            if (dec_is_attr) begin
                r_d.pat = '0;
                r_d.st  = ST_EMIT;
            end else if (at_base.hires) begin
                r_d.pat = in_data[PIX_PER_BYTE-1:0];
                r_d.st  = ST_EMIT;
            end else begin
                r_d.code  = in_data[CODE_W-1:0];
                r_d.grow  = map_row;
                r_d.galt  = at_base.alt;
                r_d.blank = at_base.blink && blink_phase;
                r_d.st    = ST_REQ;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.at    <= ATTR_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign glyph_req  = (r_q.st == ST_REQ);
    assign glyph_code = r_q.code;
    assign glyph_row  = r_q.grow;
    assign glyph_alt  = r_q.galt;
    assign pix_valid  = (r_q.st == ST_EMIT);
    assign mode_hires = r_q.at.hires;
    assign mode_50hz  = r_q.at.hz50;

    // R8: one-cycle strobe, a silent cycle, then pixels
    p_glyph_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        glyph_req |=> (!glyph_req && !pix_valid));
    p_glyph_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        glyph_req |=> ##1 pix_valid);
    // R2: control code pixels start on the next cycle
    p_attr_pix_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_data[6:5] == 2'b00) |=> pix_valid);
    // R3: colour loads
    p_fg_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_data[6:3] == 4'b0000) |=> (r_q.at.fg == $past(in_data[2:0])));
    p_bg_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_data[6:3] == 4'b0010) |=> (r_q.at.bg == $past(in_data[2:0])));
    // R6: defaults after a line start with no byte taken
    p_ls_defaults_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !(in_valid && in_ready)) |=>
        (r_q.at.fg == COL_WHITE && r_q.at.bg == COL_BLACK &&
         !r_q.at.blink && !r_q.at.dbl && !r_q.at.alt));
    // R5: mode survives a line start
    p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !(in_valid && in_ready)) |=> ($stable(mode_hires) && $stable(mode_50hz)));
    // R12: a stalled burst keeps going
    p_ready_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !in_ready) |=> pix_valid);

endmodule

// File: tb/tb_vlr_line_render.sv
`timescale 1ns/1ps
module tb_vlr_line_render;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_start = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'd0;
    logic       in_ready;
    logic [2:0] row = 3'd0;
    logic       blink_phase = 1'b0;
    logic       dbl_lower = 1'b0;
    logic       glyph_req;
    logic [6:0] glyph_code;
    logic [2:0] glyph_row;
    logic       glyph_alt;
    logic [5:0] glyph_data = 6'd0;
    logic       pix_valid;
    logic [2:0] pix_rgb;
    logic       mode_hires, mode_50hz;

    always #4 clk = ~clk;

    vlr_line_render dut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .row(row), .blink_phase(blink_phase), .dbl_lower(dbl_lower),
        .glyph_req(glyph_req), .glyph_code(glyph_code), .glyph_row(glyph_row),
        .glyph_alt(glyph_alt), .glyph_data(glyph_data),
        .pix_valid(pix_valid), .pix_rgb(pix_rgb),
        .mode_hires(mode_hires), .mode_50hz(mode_50hz)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model state
    logic [2:0] m_fg = 3'd7, m_bg = 3'd0;
    logic m_alt = 0, m_dbl = 0, m_blink = 0, m_hires = 0, m_hz50 = 0;
    logic [6:0] e_code;
    logic [2:0] e_row;
    logic       e_alt;
    logic [2:0] exp_pix [0:8191];
    string      exp_tag [0:8191];
    int wr = 0, rd = 0, line_pix = 0, byte_in_line = 0;

    function automatic logic [5:0] gfun(input logic [6:0] c, input logic [2:0] r, input logic a);
        logic [7:0] t;
        t = ({1'b0, c} * 8'd5) + ({5'd0, r} * 8'd19) + (a ? 8'd41 : 8'd0);
        return t[5:0] ^ {r, r};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // model one accepted byte and queue its six pixels
    task automatic model_byte(input logic [7:0] b);
        logic [5:0] pat;
        logic [2:0] r2, c;
        string tag;
        if (b[6:5] == 2'b00) begin
            case (b[4:3])
                2'b00: m_fg = b[2:0];
                2'b01: begin m_alt = b[0]; m_dbl = b[1]; m_blink = b[2]; end
                2'b10: m_bg = b[2:0];
                default: begin m_hires = b[2]; m_hz50 = b[1]; end
            endcase
            pat = 6'd0;
            tag = (b[4:3] == 2'b10) ? "R3" : "R2";
        end else if (m_hires) begin
            pat = b[5:0];
            tag = "R7";
        end else begin
            r2 = m_dbl ? {dbl_lower, row[2:1]} : row;
            e_code = b[6:0]; e_row = r2; e_alt = m_alt;
            pat = gfun(b[6:0], r2, m_alt);
            if (m_blink && blink_phase) begin pat = 6'd0; tag = "R10"; end
            else if (m_dbl) tag = "R11";
            else tag = (byte_in_line == 0) ? "R6" : "R8";
        end
        if (b[7]) tag = "R9";
        for (int k = 0; k < 6; k++) begin
            c = pat[5-k] ? m_fg : m_bg;
            if (b[7]) c = ~c;
            exp_pix[wr] = c;
            exp_tag[wr] = tag;
            wr++;
        end
        byte_in_line++;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_data = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        model_byte(b);
        in_valid = 1'b0;
    endtask

    task automatic end_line(input int nbytes);
        while (rd != wr) @(negedge clk);
        @(negedge clk);
        check("R1", line_pix, nbytes * 6, "pixels in line");
        check("R5", {31'd0, mode_hires}, {31'd0, m_hires}, "mode_hires");
        check("R5", {31'd0, mode_50hz}, {31'd0, m_hz50}, "mode_50hz");
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        m_fg = 3'd7; m_bg = 3'd0; m_alt = 0; m_dbl = 0; m_blink = 0;
        line_pix = 0; byte_in_line = 0;
        check("R5", {31'd0, mode_hires}, {31'd0, m_hires}, "mode_hires after line start");
    endtask

    // pixel collector and burst check
    always @(negedge clk) begin
        if (rst_n && !done && pix_valid) begin
            if (rd >= wr) begin
                check("R1", 1, 0, "unexpected pixel");
            end else begin
                check(exp_tag[rd], {29'd0, pix_rgb}, {29'd0, exp_pix[rd]}, "pixel colour");
                if ((rd % 6) != 5) check("R12", {31'd0, in_ready}, 0, "in_ready mid-burst");
                rd++;
            end
            line_pix++;
        end
    end

    // character generator model
    always @(negedge clk) begin
        if (rst_n && !done && glyph_req) begin
            check("R8", {25'd0, glyph_code}, {25'd0, e_code}, "glyph_code");
            check("R11", {29'd0, glyph_row}, {29'd0, e_row}, "glyph_row");
            check("R4", {31'd0, glyph_alt}, {31'd0, e_alt}, "glyph_alt");
            glyph_data = gfun(e_code, e_row, e_alt);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12", {31'd0, in_ready}, 1, "in_ready at reset");
        check("R1", {31'd0, pix_valid}, 0, "pix_valid at reset");
        check("R8", {31'd0, glyph_req}, 0, "glyph_req at reset");
        check("R5", {31'd0, mode_hires}, 0, "mode_hires at reset");
        check("R5", {31'd0, mode_50hz}, 0, "mode_50hz at reset");
        rst_n = 1'b1;
        @(negedge clk);

        // directed: colours set, then a line start must restore defaults
        send(8'h01); send(8'h14); send(8'h0B); send(8'h41); send(8'hC2);
        end_line(5);
        send(8'h41); send(8'h15); send(8'h4E);
        end_line(3);

        // sweep: every byte value, all rows, both phases and halves
        for (int ln = 0; ln < 16; ln++) begin
            row = ln[2:0];
            dbl_lower = ln[3];
            blink_phase = ln[0] ^ ln[2];
            for (int i = 0; i < 40; i++) begin
                int g;
                g = ln * 40 + i;
                send(8'((g * 97 + 3) % 256));
            end
            end_line(40);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL R1 watchdog: got %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule